// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block is the architectural register store of a small 16-bit processor core. It keeps two banks of seven general registers: four data registers, two address registers and a frame base register. It also holds three registers that both banks share: a user stack pointer, an interrupt stack pointer and a static base register. An external bank flag decides which bank every banked access reaches. An external stack flag decides which stack pointer the stack-pointer address reaches.

The first two data registers can also be reached as separate 8-bit upper and lower halves. Data registers can be paired into 32-bit values. Register 2 is the upper half over register 0, and register 3 is the upper half over register 1.

There are two independent combinational read ports and one synchronous write port. Each port carries a register address, a size code and a half select. Reads show the state before the current clock edge, so a read and a write to the same register in the same cycle return the old contents. Instruction decode, arithmetic and flag generation sit outside the block.

Top module: `dbank_regfile`

## Requirements
- R1: Two banks of seven registers exist. `bank_sel_i` (0 = bank 0, 1 = bank 1) selects the bank for every read and write of addresses 0-6. A write into one bank leaves every register of the other bank unchanged.
- R2: With size code 01 (word), addresses 0,1,2,3 reach data registers D0-D3, 4 and 5 reach address registers X0 and X1, and 6 reaches the frame base. A write takes `wr_data_i[15:0]`. A read returns the 16-bit value zero-extended to 32 bits.
- R3: With size code 00 (byte) at address 0 or 1, the half select 1 means bits [15:8] and 0 means bits [7:0]. A byte write stores `wr_data_i[7:0]` into that half only. A byte read returns that half zero-extended to 32 bits.
- R4: A byte access to any address other than 0 or 1 changes no register on a write and returns zero on a read.
- R5: With size code 10 (pair), address 0 reaches {D2,D0} and address 1 reaches {D3,D1}, with the upper register in bits [31:16]. A pair write updates both registers from the 32-bit write data.
- R6: A pair access to any address other than 0 or 1 changes no register on a write and returns zero on a read.
- R7: Word address 7 reaches the user stack pointer when `usp_sel_i` is 1 and the interrupt stack pointer when it is 0. Neither stack pointer is banked, and a write to one leaves the other unchanged.
- R8: Word address 8 reaches the static base register. It is shared, so a value written under one bank reads back under the other.
- R9: Addresses 9-15, and the reserved size code 11, change no register on a write and return zero on a read.
- R10: A read in the same cycle as a write to the same register returns the value held before the write. The new value is visible from the next cycle.
- R11: A synchronous active-high `rst` clears all seventeen registers to zero at the clock edge.
- R12: The two read ports work independently. Each returns its own address, size and half in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel_i | input | 1 | Active bank flag |
| usp_sel_i | input | 1 | Stack flag: 1 user, 0 interrupt stack pointer |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 4 | Write register address |
| wr_size_i | input | 2 | Write size code (00 byte, 01 word, 10 pair) |
| wr_hi_i | input | 1 | Write byte half select |
| wr_data_i | input | 32 | Write data |
| ra_addr_i | input | 4 | Read port A address |
| ra_size_i | input | 2 | Read port A size code |
| ra_hi_i | input | 1 | Read port A byte half select |
| ra_data_o | output | 32 | Read port A data |
| rb_addr_i | input | 4 | Read port B address |
| rb_size_i | input | 2 | Read port B size code |
| rb_hi_i | input | 1 | Read port B byte half select |
| rb_data_o | output | 32 | Read port B data |

## Verification
The two functions that meet in one cycle are a write and a read of the same register: a byte, word or pair write on the write port while a read port selects that register, possibly at a different width. The bench forces this with directed cycles that hit one register with both ports. Random traffic also collides often, because the addresses cluster on the nine valid codes. A collision is judged correct when the read returns the model's pre-write value in that cycle and the written value in the next. Bank flips between a write and a read are judged by the same model, which keeps both banks apart.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int RF_W      = 16;          // architectural register width
    localparam int RF_DW     = 2 * RF_W;    // port data width (pair access)
    localparam int RF_AW     = 4;           // register address width
    localparam int RF_NBANK  = 2;           // number of banks
    localparam int RF_NREG   = 7;           // banked registers per bank
    localparam int RF_NSHR   = 3;           // shared registers (usp, isp, sb)
    localparam int RF_CELLS  = RF_NREG + RF_NSHR;
    localparam int RF_NSPLIT = 2;           // registers with byte halves / pair bases
    localparam int RF_PAIR_OFS = 2;         // distance from pair base to its upper register

    localparam logic [RF_AW-1:0] ADDR_SP = 4'd7;
    localparam logic [RF_AW-1:0] ADDR_SB = 4'd8;

    localparam logic [RF_AW-1:0] CELL_USP  = 4'd7;
    localparam logic [RF_AW-1:0] CELL_ISP  = 4'd8;
    localparam logic [RF_AW-1:0] CELL_SB   = 4'd9;
    localparam logic [RF_AW-1:0] CELL_NONE = 4'hF;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_PAIR = 2'b10,
        SZ_RSVD = 2'b11
    } rf_size_e;

    typedef struct packed {
        logic [1:0]      be;    // bit1 = upper half, bit0 = lower half
        logic [RF_W-1:0] data;
    } cell_wr_t;

    // Map an architectural word address to a physical cell index.
    function automatic logic [RF_AW-1:0] cell_of(input logic [RF_AW-1:0] addr,
                                                 input logic             usp_sel);
        logic [RF_AW-1:0] c;
        if (addr < RF_AW'(RF_NREG))  c = addr;
        else if (addr == ADDR_SP)    c = usp_sel ? CELL_USP : CELL_ISP;
        else if (addr == ADDR_SB)    c = CELL_SB;
        else                         c = CELL_NONE;
        return c;
    endfunction

endpackage

// File: rtl/rf_cell.sv
module rf_cell #(
    parameter int W = rf_pkg::RF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [1:0]   be,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int HB = W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            if (be[0]) q[HB-1:0] <= d[HB-1:0];
            if (be[1]) q[W-1:HB] <= d[W-1:HB];
        end
    end
endmodule

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
    import rf_pkg::*;
#(
    parameter int W     = RF_W,
    parameter int DW    = RF_DW,
    parameter int AW    = RF_AW,
    parameter int CELLS = RF_CELLS
) (
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [1:0]            size,
    input  logic                  hi,
    input  logic [DW-1:0]         data,
    input  logic                  usp_sel,
    output cell_wr_t [CELLS-1:0]  wr
);
    localparam int HB = W / 2;

    logic [AW-1:0] tgt;

    always_comb begin
        wr  = '0;
        tgt = cell_of(addr, usp_sel);
        if (wr_en) begin
            case (rf_size_e'(size))
                SZ_BYTE: begin
                    for (int i = 0; i < RF_NSPLIT; i++) begin
                        if (addr == AW'(i)) begin
                            wr[i].be   = hi ? 2'b10 : 2'b01;
                            wr[i].data = {2{data[HB-1:0]}};
                        end
                    end
                end
                SZ_WORD: begin
                    for (int i = 0; i < CELLS; i++) begin
                        if (tgt == AW'(i)) begin
                            wr[i].be   = 2'b11;
                            wr[i].data = data[W-1:0];
                        end
                    end
                end
                SZ_PAIR: begin
                    for (int i = 0; i < RF_NSPLIT; i++) begin
                        if (addr == AW'(i)) begin
                            wr[i].be                 = 2'b11;
                            wr[i].data               = data[W-1:0];
                            wr[i + RF_PAIR_OFS].be   = 2'b11;
                            wr[i + RF_PAIR_OFS].data = data[DW-1:W];
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
    import rf_pkg::*;
#(
    parameter int W     = RF_W,
    parameter int DW    = RF_DW,
    parameter int AW    = RF_AW,
    parameter int CELLS = RF_CELLS
) (
    input  logic [CELLS-1:0][W-1:0] view,
    input  logic [AW-1:0]           addr,
    input  logic [1:0]              size,
    input  logic                    hi,
    input  logic                    usp_sel,
    output logic [DW-1:0]           data_o
);
    localparam int HB = W / 2;

    logic [AW-1:0] tgt;

    always_comb begin
        data_o = '0;
        tgt    = cell_of(addr, usp_sel);
        case (rf_size_e'(size))
            SZ_BYTE: begin
                for (int i = 0; i < RF_NSPLIT; i++) begin
                    if (addr == AW'(i)) begin
                        data_o = hi ? DW'(view[i][W-1:HB]) : DW'(view[i][HB-1:0]);
                    end
                end
            end
            SZ_WORD: begin
                for (int i = 0; i < CELLS; i++) begin
                    if (tgt == AW'(i)) data_o = DW'(view[i]);
                end
            end
            SZ_PAIR: begin
                for (int i = 0; i < RF_NSPLIT; i++) begin
                    if (addr == AW'(i)) data_o = {view[i + RF_PAIR_OFS], view[i]};
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dbank_regfile.sv
module dbank_regfile
    import rf_pkg::*;
#(
    parameter int W      = RF_W,
    parameter int DW     = RF_DW,
    parameter int AW     = RF_AW,
    parameter int NBANK  = RF_NBANK,
    parameter int NREG   = RF_NREG,
    parameter int NSHR   = RF_NSHR,
    localparam int CELLS  = NREG + NSHR,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] bank_sel_i,
    input  logic              usp_sel_i,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [1:0]        wr_size_i,
    input  logic              wr_hi_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic [AW-1:0]     ra_addr_i,
    input  logic [1:0]        ra_size_i,
    input  logic              ra_hi_i,
    output logic [DW-1:0]     ra_data_o,
    input  logic [AW-1:0]     rb_addr_i,
    input  logic [1:0]        rb_size_i,
    input  logic              rb_hi_i,
    output logic [DW-1:0]     rb_data_o
);
    cell_wr_t [CELLS-1:0]             wr;
    logic [NBANK-1:0][NREG-1:0][W-1:0] bank_q;
    logic [NSHR-1:0][W-1:0]            shr_q;
    logic [CELLS-1:0][W-1:0]           view;

    rf_wr_decode #(.W(W), .DW(DW), .AW(AW), .CELLS(CELLS)) u_dec (
        .wr_en   (wr_en_i),
        .addr    (wr_addr_i),
        .size    (wr_size_i),
        .hi      (wr_hi_i),
        .data    (wr_data_i),
        .usp_sel (usp_sel_i),
        .wr      (wr)
    );

    // Banked storage: one decoded write, gated by the bank flag per bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            rf_cell #(.W(W)) u_cell (
                .clk (clk),
                .rst (rst),
                .en  (bank_sel_i == BANK_W'(b)),
                .be  (wr[r].be),
                .d   (wr[r].data),
                .q   (bank_q[b][r])
            );
        end
    end

    // Shared storage: stack pointers and static base.
    for (genvar s = 0; s < NSHR; s++) begin : g_shr
        rf_cell #(.W(W)) u_cell (
            .clk (clk),
            .rst (rst),
            .en  (1'b1),
            .be  (wr[NREG + s].be),
            .d   (wr[NREG + s].data),
            .q   (shr_q[s])
        );
    end

    always_comb begin
        for (int r = 0; r < NREG; r++) view[r] = bank_q[bank_sel_i][r];
        for (int s = 0; s < NSHR; s++) view[NREG + s] = shr_q[s];
    end

    rf_rd_port #(.W(W), .DW(DW), .AW(AW), .CELLS(CELLS)) u_rda (
        .view    (view),
        .addr    (ra_addr_i),
        .size    (ra_size_i),
        .hi      (ra_hi_i),
        .usp_sel (usp_sel_i),
        .data_o  (ra_data_o)
    );

    rf_rd_port #(.W(W), .DW(DW), .AW(AW), .CELLS(CELLS)) u_rdb (
        .view    (view),
        .addr    (rb_addr_i),
        .size    (rb_size_i),
        .hi      (rb_hi_i),
        .usp_sel (usp_sel_i),
        .data_o  (rb_data_o)
    );
endmodule

// File: rtl/rf_checker.sv
module rf_checker
    import rf_pkg::*;
#(
    parameter int W     = RF_W,
    parameter int DW    = RF_DW,
    parameter int AW    = RF_AW,
    parameter int NBANK = RF_NBANK,
    parameter int NREG  = RF_NREG,
    parameter int NSHR  = RF_NSHR
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              bank_sel_i,
    input logic                              usp_sel_i,
    input logic                              wr_en_i,
    input logic [AW-1:0]                     wr_addr_i,
    input logic [1:0]                        wr_size_i,
    input logic                              wr_hi_i,
    input logic [DW-1:0]                     wr_data_i,
    input logic [NBANK-1:0][NREG-1:0][W-1:0] bank_q,
    input logic [NSHR-1:0][W-1:0]            shr_q
);
    localparam int HB = W / 2;

    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    logic is_byte, is_word, is_pair, is_rsvd;
    assign is_byte = wr_en_i && (wr_size_i == SZ_BYTE);
    assign is_word = wr_en_i && (wr_size_i == SZ_WORD);
    assign is_pair = wr_en_i && (wr_size_i == SZ_PAIR);
    assign is_rsvd = wr_en_i && ((wr_size_i == SZ_RSVD) || (wr_addr_i > ADDR_SB));

    p_bank_iso_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !bank_sel_i) |=> $stable(bank_q[1]));

    p_bank_iso_b1_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && bank_sel_i) |=> $stable(bank_q[0]));

    p_word_wr_r2: assert property (@(posedge clk) disable iff (rst)
        (is_word && !bank_sel_i && wr_addr_i == 4'd4) |=> (bank_q[0][4] == $past(wr_data_i[W-1:0])));

    p_byte_half_r3: assert property (@(posedge clk) disable iff (rst)
        (is_byte && !bank_sel_i && wr_addr_i == 4'd0 && !wr_hi_i) |=> $stable(bank_q[0][0][W-1:HB]));

    p_byte_half_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (is_byte && bank_sel_i && wr_addr_i == 4'd1 && wr_hi_i) |=> $stable(bank_q[1][1][HB-1:0]));

    p_byte_other_r4: assert property (@(posedge clk) disable iff (rst)
        (is_byte && wr_addr_i > 4'd1) |=> ($stable(bank_q) && $stable(shr_q)));

    p_pair_bad_r6: assert property (@(posedge clk) disable iff (rst)
        (is_pair && wr_addr_i > 4'd1) |=> ($stable(bank_q) && $stable(shr_q)));

    p_sp_unbanked_r7: assert property (@(posedge clk) disable iff (rst)
        (is_word && wr_addr_i == ADDR_SP && usp_sel_i)
            |=> ($stable(shr_q[1]) && shr_q[0] == $past(wr_data_i[W-1:0])));

    p_rsvd_r9: assert property (@(posedge clk) disable iff (rst)
        is_rsvd |=> ($stable(bank_q) && $stable(shr_q)));

    p_reset_r11: assert property (@(posedge clk)
        rst_d |-> (bank_q == '0 && shr_q == '0));
endmodule

bind dbank_regfile rf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bank_sel_i (bank_sel_i),
    .usp_sel_i  (usp_sel_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_size_i  (wr_size_i),
    .wr_hi_i    (wr_hi_i),
    .wr_data_i  (wr_data_i),
    .bank_q     (bank_q),
    .shr_q      (shr_q)
);

// File: tb/dbank_regfile_bench.sv
module dbank_regfile_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bank_sel_i = 1'b0;
    logic        usp_sel_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_addr_i = '0;
    logic [1:0]  wr_size_i = 2'b01;
    logic        wr_hi_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [3:0]  ra_addr_i = '0;
    logic [1:0]  ra_size_i = 2'b01;
    logic        ra_hi_i = 1'b0;
    logic [31:0] ra_data_o;
    logic [3:0]  rb_addr_i = '0;
    logic [1:0]  rb_size_i = 2'b01;
    logic        rb_hi_i = 1'b0;
    logic [31:0] rb_data_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    dbank_regfile u_dbank_regfile (
        .clk(clk), .rst(rst), .bank_sel_i(bank_sel_i), .usp_sel_i(usp_sel_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_size_i(wr_size_i),
        .wr_hi_i(wr_hi_i), .wr_data_i(wr_data_i),
        .ra_addr_i(ra_addr_i), .ra_size_i(ra_size_i), .ra_hi_i(ra_hi_i), .ra_data_o(ra_data_o),
        .rb_addr_i(rb_addr_i), .rb_size_i(rb_size_i), .rb_hi_i(rb_hi_i), .rb_data_o(rb_data_o)
    );

    // Reference model
    logic [15:0] m_bank [2][7];
    logic [15:0] m_usp, m_isp, m_sb;

    task automatic m_clear();
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 7; r++) m_bank[b][r] = '0;
        m_usp = '0; m_isp = '0; m_sb = '0;
    endtask

    function automatic logic [15:0] m_word(input bit b, input int a, input bit us);
        if (a < 7)  return m_bank[b][a];
        if (a == 7) return us ? m_usp : m_isp;
        if (a == 8) return m_sb;
        return '0;
    endfunction

    function automatic logic [31:0] exp_rd(input bit b, input int a, input logic [1:0] sz,
                                           input bit hi, input bit us);
        case (sz)
            2'b00: if (a < 2) return hi ? {24'h0, m_bank[b][a][15:8]} : {24'h0, m_bank[b][a][7:0]};
            2'b01: if (a <= 8) return {16'h0, m_word(b, a, us)};
            2'b10: if (a < 2) return {m_bank[b][a+2], m_bank[b][a]};
            default: ;
        endcase
        return '0;
    endfunction

    task automatic m_write(input bit b, input int a, input logic [1:0] sz,
                           input bit hi, input bit us, input logic [31:0] d);
        case (sz)
            2'b00: if (a < 2) begin
                if (hi) m_bank[b][a][15:8] = d[7:0];
                else    m_bank[b][a][7:0]  = d[7:0];
            end
            2'b01: begin
                if (a < 7)       m_bank[b][a] = d[15:0];
                else if (a == 7) begin
                    if (us) m_usp = d[15:0]; else m_isp = d[15:0];
                end
                else if (a == 8) m_sb = d[15:0];
            end
            2'b10: if (a < 2) begin
                m_bank[b][a]   = d[15:0];
                m_bank[b][a+2] = d[31:16];
            end
            default: ;
        endcase
    endtask

    function automatic string req_of(input int a, input logic [1:0] sz);
        case (sz)
            2'b00: return (a < 2) ? "R3" : "R4";
            2'b01: return (a < 7) ? "R2" : (a == 7) ? "R7" : (a == 8) ? "R8" : "R9";
            2'b10: return (a < 2) ? "R5" : "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called after inputs are driven just past a negative edge: check reads,
    // commit the write to the model, move to the next negative edge.
    task automatic step(input string tag);
        #2;
        chk((tag != "") ? tag : req_of(int'(ra_addr_i), ra_size_i), ra_data_o,
            exp_rd(bank_sel_i, int'(ra_addr_i), ra_size_i, ra_hi_i, usp_sel_i));
        chk((tag != "") ? tag : req_of(int'(rb_addr_i), rb_size_i), rb_data_o,
            exp_rd(bank_sel_i, int'(rb_addr_i), rb_size_i, rb_hi_i, usp_sel_i));
        if (wr_en_i)
            m_write(bank_sel_i, int'(wr_addr_i), wr_size_i, wr_hi_i, usp_sel_i, wr_data_i);
        @(negedge clk);
    endtask

    task automatic set_wr(input bit en, input int a, input logic [1:0] sz, input bit hi,
                          input logic [31:0] d);
        wr_en_i = en; wr_addr_i = 4'(a); wr_size_i = sz; wr_hi_i = hi; wr_data_i = d;
    endtask

    task automatic set_rd(input int a0, input logic [1:0] s0, input bit h0,
                          input int a1, input logic [1:0] s1, input bit h1);
        ra_addr_i = 4'(a0); ra_size_i = s0; ra_hi_i = h0;
        rb_addr_i = 4'(a1); rb_size_i = s1; rb_hi_i = h1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: everything reads zero after reset, both banks, both stack pointers
        for (int a = 0; a < 9; a++) begin
            bank_sel_i = a[0]; usp_sel_i = a[1];
            set_rd(a, 2'b01, 0, a, 2'b01, 0);
            step("R11");
        end

        // R1: write bank 0, bank 1 stays at zero
        bank_sel_i = 0; set_wr(1, 0, 2'b01, 0, 32'h0000_AAAA); set_rd(0, 2'b01, 0, 0, 2'b01, 0);
        step("R1");
        set_wr(0, 0, 2'b01, 0, 0); bank_sel_i = 1;
        step("R1");
        bank_sel_i = 0;
        step("R1");

        // R10: collision of word write and word read on D2, then new value visible
        set_wr(1, 2, 2'b01, 0, 32'h0000_1234); set_rd(2, 2'b01, 0, 2, 2'b01, 0);
        step("R10");
        set_wr(0, 0, 2'b01, 0, 0);
        step("R10");
        // R10: pair write over D0/D2 while reading byte and pair
        set_wr(1, 0, 2'b10, 0, 32'hCAFE_5A5A); set_rd(0, 2'b00, 1, 0, 2'b10, 0);
        step("R10");
        set_wr(0, 0, 2'b01, 0, 0);
        step("R5");

        // R3: byte writes to upper then lower half of D1 in bank 1
        bank_sel_i = 1;
        set_wr(1, 1, 2'b00, 1, 32'h0000_00C3); set_rd(1, 2'b01, 0, 1, 2'b00, 1);
        step("R3");
        set_wr(1, 1, 2'b00, 0, 32'h0000_FF3C);
        step("R3");
        set_wr(0, 0, 2'b01, 0, 0); set_rd(1, 2'b01, 0, 1, 2'b00, 0);
        step("R3");

        // R7: user SP write leaves interrupt SP untouched
        usp_sel_i = 1; set_wr(1, 7, 2'b01, 0, 32'h0000_BEEF); set_rd(7, 2'b01, 0, 8, 2'b01, 0);
        step("R7");
        set_wr(0, 0, 2'b01, 0, 0); usp_sel_i = 0;
        step("R7");
        usp_sel_i = 1; bank_sel_i = 0;
        step("R7");

        // R8: static base shared across banks
        set_wr(1, 8, 2'b01, 0, 32'h0000_7E57);
        step("R8");
        set_wr(0, 0, 2'b01, 0, 0); bank_sel_i = 1; set_rd(8, 2'b01, 0, 8, 2'b01, 0);
        step("R8");

        // R12: two ports read different registers with different sizes
        set_rd(1, 2'b10, 0, 8, 2'b01, 0);
        step("R12");

        // R4, R6, R9: ignored writes, read back everything after each
        set_wr(1, 4, 2'b00, 0, 32'hFFFF_FFFF); step("R4");
        set_wr(1, 3, 2'b10, 0, 32'hFFFF_FFFF); step("R6");
        set_wr(1, 0, 2'b11, 0, 32'hFFFF_FFFF); step("R9");
        set_wr(1, 12, 2'b01, 0, 32'hFFFF_FFFF); step("R9");
        set_wr(0, 0, 2'b01, 0, 0);
        for (int a = 0; a < 9; a++) begin
            set_rd(a, 2'b01, 0, a, 2'b00, a[0]);
            step("");
        end

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            bank_sel_i = 1'($urandom_range(0, 1));
            usp_sel_i  = 1'($urandom_range(0, 1));
            set_wr($urandom_range(0, 9) < 7,
                   ($urandom_range(0, 9) < 8) ? $urandom_range(0, 8) : $urandom_range(0, 15),
                   2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom());
            set_rd(($urandom_range(0, 9) < 8) ? $urandom_range(0, 8) : $urandom_range(0, 15),
                   2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                   $urandom_range(0, 8), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
            if (n == 2000) begin
                // R11: reset in the middle of traffic
                set_wr(0, 0, 2'b01, 0, 0);
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                m_clear();
                for (int a = 0; a < 9; a++) begin
                    set_rd(a, 2'b01, 0, a, 2'b01, 0);
                    step("R11");
                end
            end else begin
                step("");
            end
        end

        summary();
        $finish;
    end
endmodule